// File: doc/BRIEF.md
# Change-of-State Input Interrupt Detector

The block watches a 32-bit digital input word and raises an interrupt line when a programmed condition is met on a window of sixteen interrupt-capable channels, channels 4 through 19. Every other input bit is ignored by the detector. Three operating modes are offered: off, an edge mode that ORs per-channel edge events, and a level mode that fires only when all selected channels sit at their chosen levels together.

Software configures the detector through a small write port. It programs two 16-bit channel masks first: one for rising edges or high levels, one for falling edges or low levels. It then writes the mode. Writing the off mode cancels detection. A status word reports a sticky event flag together with a snapshot of the sixteen interrupt-capable inputs, taken when the flag was set. Software clears the flag by writing one to it.

In level mode a firing locks the detector. It cannot fire again until one of the selected inputs changes level. This prevents a steady satisfied pattern from retriggering as soon as software clears the flag.

Top module: `cos_irq_detect`

## Requirements
- R1: Only input bits 4..19 influence detection; toggling bits 0..3 or 20..31 never sets the flag and never releases the level-mode lock.
- R2: The control register (wr_addr 0) holds the mode in wr_data[1:0]: 0 = off, 1 = edge, 2 = level, 3 = treated as off. In off the flag is never set.
- R3: In edge mode the flag sets when any channel whose bit is set in the rise mask (wr_addr 1, wr_data[15:0], bit k = input 4+k) goes 0 to 1. It also sets when any channel set in the fall mask (wr_addr 2, same layout) goes 1 to 0.
- R4: In level mode the flag sets when every channel selected in either mask is at its level: high for the rise mask, low for the fall mask. With no channel selected it never fires. A channel selected in both masks is never satisfied.
- R5: After a level-mode firing, no further firing happens until some selected input changes level, even after the flag is cleared.
- R6: status_o holds the flag at bit 31 and the snapshot of inputs 19..4 at bits 19:4. All other bits read 0. The snapshot updates only in the cycle the flag is set.
- R7: A write to wr_addr 3 with wr_data[31] = 1 clears the flag, and a write with wr_data[31] = 0 leaves it. The flag stays set until cleared. An event in the same cycle as the clear wins.
- R8: Any write to wr_addr 0, 1 or 2 clears a pending flag and re-arms the level-mode lock.
- R9: An input change driven just after a rising clock edge reaches irq_o after the third following rising edge: two synchronizer stages plus the flag register.
- R10: After reset the flag, snapshot, masks and mode are zero, so irq_o = 0 and status_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 rise/high mask, 2 fall/low mask, 3 status clear |
| wr_data | input | 32 | Write data |
| din | input | 32 | Asynchronous digital input word |
| irq_o | output | 1 | Interrupt request (sticky flag) |
| status_o | output | 32 | Flag plus input snapshot |

## Verification
An input driven at a falling edge passes two synchronizer flops and the flag register, so its effect is due after the third rising edge. The bench reads irq_o and status_o at the falling edge after that. A register write is applied at the next rising edge. A configuration write therefore shows a cleared flag at the falling edge right after it, and a level condition that still holds shows the flag again one cycle later. The bench samples at exactly those points. The clear-versus-event race is staged so that both land on the same rising edge.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;

    localparam int COS_CH_N   = 16;
    localparam int FLAG_BIT   = 31;
    localparam int WORD_W     = 32;

    typedef enum logic [1:0] {
        CM_OFF   = 2'd0,
        CM_EDGE  = 2'd1,
        CM_LEVEL = 2'd2,
        CM_RSVD  = 2'd3
    } cos_mode_e;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_RISE = 2'd1,
        RA_FALL = 2'd2,
        RA_STAT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        cos_mode_e               mode;
        logic [COS_CH_N-1:0]     hi_mask;
        logic [COS_CH_N-1:0]     lo_mask;
    } cos_cfg_t;

    // Per-channel level check: a channel picked in both masks never passes,
    // an unselected channel always passes.
    function automatic logic lvl_ok(input logic hi, input logic lo, input logic v);
        return (hi & ~lo & v) | (lo & ~hi & ~v) | (~hi & ~lo);
    endfunction

endpackage

// File: rtl/cos_irq_sync.sv
module cos_irq_sync #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o
);
    logic [N-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_o  <= '0;
            prev_o <= '0;
        end else begin
            meta_q <= d_i;
            cur_o  <= meta_q;
            prev_o <= cur_o;
        end
    end

    // R9
    hist_track_chk: assert property (@(posedge clk) disable iff (rst)
        prev_o == $past(cur_o));

endmodule

// File: rtl/cos_irq_eval.sv
module cos_irq_eval
    import cos_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cos_cfg_t            cfg_i,
    input  logic                cfg_wr_i,
    input  logic [COS_CH_N-1:0] cur_i,
    input  logic [COS_CH_N-1:0] prev_i,
    output logic                hit_o
);
    logic [COS_CH_N-1:0] edge_v;
    logic [COS_CH_N-1:0] sat_v;
    logic [COS_CH_N-1:0] sel;
    logic                sel_chg;
    logic                all_sat;
    logic                lock_q;

    for (genvar i = 0; i < COS_CH_N; i++) begin : g_ch
        assign edge_v[i] = (cfg_i.hi_mask[i] &  cur_i[i] & ~prev_i[i])
                         | (cfg_i.lo_mask[i] & ~cur_i[i] &  prev_i[i]);
        assign sat_v[i]  = lvl_ok(cfg_i.hi_mask[i], cfg_i.lo_mask[i], cur_i[i]);
    end

    assign sel     = cfg_i.hi_mask | cfg_i.lo_mask;
    assign sel_chg = |((cur_i ^ prev_i) & sel);
    assign all_sat = (&sat_v) & (|sel);

    always_comb begin
        unique case (cfg_i.mode)
            CM_EDGE:  hit_o = |edge_v;
            CM_LEVEL: hit_o = all_sat & ~lock_q;
            default:  hit_o = 1'b0;
        endcase
        if (cfg_wr_i) hit_o = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || cfg_wr_i)
            lock_q <= 1'b0;
        else if (cfg_i.mode == CM_LEVEL && hit_o)
            lock_q <= 1'b1;
        else if (sel_chg)
            lock_q <= 1'b0;
    end

    // R5
    lock_block_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> !hit_o);

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !sel_chg && !cfg_wr_i) |=> lock_q);

endmodule

// File: rtl/cos_irq_detect.sv
module cos_irq_detect
    import cos_irq_pkg::*;
#(
    parameter int IN_W  = 32,
    parameter int CH_LO = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IN_W-1:0]   din,
    output logic              irq_o,
    output logic [WORD_W-1:0] status_o
);
    localparam int CH_HI = CH_LO + COS_CH_N - 1;

    cos_cfg_t            cfg_q;
    logic                cfg_wr;
    logic                clr_req;
    logic                hit;
    logic                flag_q;
    logic [COS_CH_N-1:0] snap_q;
    logic [COS_CH_N-1:0] cur, prev;
    logic                unused_bits;

    assign unused_bits = ^{din, wr_data};

    assign cfg_wr  = wr_en && (wr_addr != RA_STAT);
    assign clr_req = wr_en && (wr_addr == RA_STAT) && wr_data[FLAG_BIT];

    cos_irq_sync #(.N(COS_CH_N)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_i    (din[CH_HI:CH_LO]),
        .cur_o  (cur),
        .prev_o (prev)
    );

    cos_irq_eval u_eval (
        .clk      (clk),
        .rst      (rst),
        .cfg_i    (cfg_q),
        .cfg_wr_i (cfg_wr),
        .cur_i    (cur),
        .prev_i   (prev),
        .hit_o    (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: CM_OFF, hi_mask: '0, lo_mask: '0};
        end else if (cfg_wr) begin
            unique case (wr_addr)
                RA_CTRL: cfg_q.mode    <= cos_mode_e'(wr_data[1:0]);
                RA_RISE: cfg_q.hi_mask <= wr_data[COS_CH_N-1:0];
                default: cfg_q.lo_mask <= wr_data[COS_CH_N-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            snap_q <= '0;
        end else begin
            if (cfg_wr)       flag_q <= 1'b0;
            else if (hit)     flag_q <= 1'b1;
            else if (clr_req) flag_q <= 1'b0;
            if (hit) snap_q <= cur;
        end
    end

    always_comb begin
        status_o = '0;
        status_o[FLAG_BIT] = flag_q;
        status_o[CH_HI:CH_LO] = snap_q;
    end
    assign irq_o = flag_q;

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.mode == CM_OFF || cfg_q.mode == CM_RSVD) && !irq_o) |=> !irq_o);

    // R8
    cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != RA_STAT) |=> !irq_o);

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !hit) |=> !irq_o);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !wr_en) |=> irq_o);

    // R6
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(status_o[CH_HI:CH_LO]));

    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[FLAG_BIT-1:CH_HI+1] == '0 && status_o[CH_LO-1:0] == '0);

endmodule

// File: tb/cos_irq_detect_bench.sv
module cos_irq_detect_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] din = '0;
    logic        irq_o;
    logic [31:0] status_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cos_irq_detect u_cos_irq_detect (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .din(din), .irq_o(irq_o), .status_o(status_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive a new input word and wait until its effect is due on irq_o (R9)
    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        din = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_stat(input logic f, input logic [31:0] v);
        return {f, 11'b0, v[19:4], 4'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic fire;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 irq", {31'b0, irq_o}, 32'd0);
        chk("R10 status", status_o, 32'd0);

        // R3/R1/R6 rising sweep over every input bit
        wr(2'd1, 32'h0000FFFF);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'd1);
        for (int ch = 0; ch < 32; ch++) begin
            v = 32'd1 << ch;
            fire = (ch >= 4 && ch <= 19);
            drive(v);
            chk($sformatf("R3/R1 rise ch%0d irq", ch), {31'b0, irq_o}, {31'b0, fire});
            if (fire) chk($sformatf("R6 snapshot ch%0d", ch), status_o, exp_stat(1'b1, v));
            wr(2'd3, 32'h80000000);
            chk("R7 w1c", {31'b0, irq_o}, 32'd0);
            drive(32'h0);
            chk($sformatf("R3 no fall ch%0d", ch), {31'b0, irq_o}, 32'd0);
        end

        // R9 latency: not yet after two edges, set after the third
        @(negedge clk); din = 32'h00000010;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R9 early", {31'b0, irq_o}, 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R9 due", {31'b0, irq_o}, 32'd1);
        // R7: zero in bit 31 leaves the flag, and the flag is sticky
        wr(2'd3, 32'h7FFFFFFF);
        repeat (4) @(negedge clk);
        chk("R7 keep", {31'b0, irq_o}, 32'd1);
        // R7 clear racing a new event: event wins
        @(negedge clk); din = 32'h00000030;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'h80000000;
        @(negedge clk); wr_en = 1'b0;
        chk("R7 race", status_o, exp_stat(1'b1, 32'h30));

        // R3 falling sweep
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0000FFFF);
        chk("R8 mask clears", {31'b0, irq_o}, 32'd0);
        drive(32'hFFFFFFFF);
        chk("R3 rise ignored", {31'b0, irq_o}, 32'd0);
        for (int ch = 4; ch < 20; ch++) begin
            v = ~(32'd1 << ch);
            drive(v);
            chk($sformatf("R3 fall ch%0d", ch), status_o, exp_stat(1'b1, v));
            wr(2'd3, 32'h80000000);
            drive(32'hFFFFFFFF);
            chk($sformatf("R3 refall ch%0d", ch), {31'b0, irq_o}, 32'd0);
        end

        // R2 off and reserved modes
        for (int m = 0; m < 4; m += 3) begin
            wr(2'd0, m);
            wr(2'd1, 32'h0000FFFF);
            drive(32'h0);
            drive(32'hFFFFFFFF);
            chk($sformatf("R2 mode%0d quiet", m), {31'b0, irq_o}, 32'd0);
        end

        // R4 level mode, none selected
        wr(2'd1, 32'h0); wr(2'd2, 32'h0);
        wr(2'd0, 32'd2);
        drive(32'h0);
        chk("R4 none selected", {31'b0, irq_o}, 32'd0);
        // inputs 8..11 high, 4,5 low
        wr(2'd1, 32'h000000F0);
        wr(2'd2, 32'h00000003);
        drive(32'h00000E00);
        chk("R4 partial", {31'b0, irq_o}, 32'd0);
        drive(32'h00000F00);
        chk("R4 all met", status_o, exp_stat(1'b1, 32'h00000F00));
        wr(2'd3, 32'h80000000);
        repeat (3) @(negedge clk);
        chk("R5 locked", {31'b0, irq_o}, 32'd0);
        drive(32'h02001F01);
        chk("R5/R1 unselected toggles", {31'b0, irq_o}, 32'd0);
        drive(32'h02001F11);
        chk("R5 unlock away", {31'b0, irq_o}, 32'd0);
        drive(32'h02001F01);
        chk("R5 refire", status_o, exp_stat(1'b1, 32'h00001F00));
        // R8 rewriting a mask clears and re-arms
        wr(2'd1, 32'h000000F0);
        chk("R8 cleared", {31'b0, irq_o}, 32'd0);
        @(negedge clk);
        chk("R8 rearmed", {31'b0, irq_o}, 32'd1);
        // R4 channel 12 in both masks never satisfied
        wr(2'd1, 32'h000001F0);
        wr(2'd2, 32'h00000103);
        drive(32'h00000F00);
        chk("R4 both low", {31'b0, irq_o}, 32'd0);
        drive(32'h00001F00);
        chk("R4 both high", {31'b0, irq_o}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule